// File: doc/BRIEF.md
# Stack Push/Pop Run Fuser

This decode-stage unit watches a stream of decoded operations, each tagged as a push, a pop or anything else, together with a register number. Normally every push would be a store followed by a stack-pointer decrement, and each one would have to wait for the previous decrement. The unit collects a run of back-to-back pushes and emits it as one group: a store per register at its own fixed negative offset from the stack pointer as it was before the run, plus a single stack-pointer subtraction covering the whole run. None of these micro-ops depends on another, so a later issue stage can start them all in the same cycle.

Runs of pops are handled in the mirror image: loads at rising non-negative offsets from the unchanged stack pointer and one addition by the total size. Each emitted group with two or more memory operations carries an atomic flag. Stores below the stack pointer are unsafe if an interrupt lands before the pointer moves, so the flag tells later stages not to accept an interrupt until the whole group has retired. Operations that cannot be fused leave on a separate lane in their original form, in order after any group flushed in the same cycle.

Top module: `push_pop_fuser`

## Requirements
- R1: A flushed run of N pushes (N of 2 or more) drives group slots 0..N-1 valid, with slot k (counting from 0) holding the k-th pushed register and offset -8*(k+1), grp_pop low.
- R2: A flushed run of N pops (N of 2 or more) drives slots 0..N-1 valid, with slot k holding the k-th popped register and offset +8*k, grp_pop high.
- R3: A fused group raises its stack-pointer slot (grp_valid bit 4) exactly once, with grp_sp_amt equal to 8*N; grp_pop low means subtract and high means add.
- R4: A run never exceeds 4 operations: the 4th joining operation flushes the group in the next cycle, and a 5th operation starts a fresh run.
- R5: A run ends, and its group appears in the cycle after, when the next accepted input is of the other kind (push/pop), a non-fusable operation, or when in_valid is low.
- R6: A push or pop whose register equals the stack-pointer register (default 4) is never fused: it ends any open run and leaves on the solo lane unchanged.
- R7: A run of exactly one operation leaves in slot 0 with grp_raw high, no stack-pointer slot and grp_atomic low.
- R8: grp_atomic is high for, and only for, groups with two or more memory operations.
- R9: An operation of kind other (in_kind 0 or 3) appears on the solo lane with its kind and register one cycle after it is taken, in the same cycle as any group it flushed.
- R10: During and right after reset every valid bit, grp_atomic, grp_raw and solo_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_kind | input | 2 | 0 other, 1 push, 2 pop, 3 other |
| in_reg | input | 5 | Register pushed, popped or carried |
| grp_valid | output | 5 | Per-slot valid; bits 0..3 memory ops, bit 4 stack-pointer update |
| grp_reg | output | 20 | Register per memory slot, 5 bits each, slot 0 lowest |
| grp_off | output | 32 | Signed byte offset per memory slot, 8 bits each |
| grp_sp_amt | output | 6 | Bytes by which the stack pointer moves |
| grp_pop | output | 1 | Group is loads plus addition (else stores plus subtraction) |
| grp_raw | output | 1 | Slot 0 is a single unfused push or pop |
| grp_atomic | output | 1 | Block interrupt acceptance until the group retires |
| solo_valid | output | 1 | Unfused operation on the solo lane |
| solo_kind | output | 2 | Kind of the solo operation |
| solo_reg | output | 5 | Register of the solo operation |

## Verification
The hardest case to reach is a cycle that flushes a group and passes a solo operation at once, especially when the run holds exactly three pushes and the breaking operation is a push naming the stack-pointer register. Directed sequences build runs of each length from one to five and break them with every kind of terminator, then a long pseudo-random stream drawing registers from a small range keeps the stack-pointer register and kind changes frequent, while a queue-based model predicts every output each cycle.

// File: rtl/push_pop_fuser.sv
module push_pop_fuser #(
  parameter int MAX_RUN = 4,
  parameter int SLOT    = 8,
  parameter int REG_W   = 5,
  parameter int OFF_W   = 8,
  parameter int AMT_W   = 6,
  parameter int SP_REG  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [1:0]               in_kind,
  input  logic [REG_W-1:0]         in_reg,
  output logic [MAX_RUN:0]         grp_valid,
  output logic [MAX_RUN*REG_W-1:0] grp_reg,
  output logic [MAX_RUN*OFF_W-1:0] grp_off,
  output logic [AMT_W-1:0]         grp_sp_amt,
  output logic                     grp_pop,
  output logic                     grp_raw,
  output logic                     grp_atomic,
  output logic                     solo_valid,
  output logic [1:0]               solo_kind,
  output logic [REG_W-1:0]         solo_reg
);
  localparam int CNT_W = $clog2(MAX_RUN + 1);

  logic [CNT_W-1:0] acc_n;
  logic             acc_pop;
  logic [REG_W-1:0] acc_reg [MAX_RUN];

  logic             in_pop, fuse_in, joins, full;
  logic [CNT_W-1:0] em_n;
  logic             em_pop;
  logic [REG_W-1:0] em_reg [MAX_RUN];

  assign in_pop  = in_kind == 2'd2;
  assign fuse_in = in_valid && (in_kind == 2'd1 || in_kind == 2'd2) && in_reg != REG_W'(SP_REG);
  assign joins   = fuse_in && (acc_n == '0 || acc_pop == in_pop);
  assign full    = joins && acc_n == CNT_W'(MAX_RUN - 1);
  assign em_n    = full ? CNT_W'(MAX_RUN) : (joins ? '0 : acc_n);
  assign em_pop  = full ? in_pop : acc_pop;

  always_comb
    for (int i = 0; i < MAX_RUN; i++)
      em_reg[i] = (full && i == MAX_RUN - 1) ? in_reg : acc_reg[i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_n      <= '0;
      acc_pop    <= 1'b0;
      grp_valid  <= '0;
      grp_reg    <= '0;
      grp_off    <= '0;
      grp_sp_amt <= '0;
      grp_pop    <= 1'b0;
      grp_raw    <= 1'b0;
      grp_atomic <= 1'b0;
      solo_valid <= 1'b0;
      solo_kind  <= '0;
      solo_reg   <= '0;
      for (int i = 0; i < MAX_RUN; i++) acc_reg[i] <= '0;
    end else begin
      if (joins && !full) begin
        for (int i = 0; i < MAX_RUN; i++)
          if (acc_n == CNT_W'(i)) acc_reg[i] <= in_reg;
        acc_n   <= acc_n + 1'b1;
        acc_pop <= in_pop;
      end else if (!joins && fuse_in) begin
        acc_reg[0] <= in_reg;
        acc_n      <= CNT_W'(1);
        acc_pop    <= in_pop;
      end else begin
        acc_n <= '0;
      end

      for (int i = 0; i < MAX_RUN; i++) begin
        grp_valid[i]              <= CNT_W'(i) < em_n;
        grp_reg[i*REG_W +: REG_W] <= em_reg[i];
        grp_off[i*OFF_W +: OFF_W] <= em_pop ? OFF_W'(i * SLOT) : OFF_W'(-(i + 1) * SLOT);
      end
      grp_valid[MAX_RUN] <= em_n >= CNT_W'(2);
      grp_sp_amt         <= (em_n >= CNT_W'(2)) ? AMT_W'(int'(em_n) * SLOT) : '0;
      grp_pop            <= em_pop && em_n != '0;
      grp_raw            <= em_n == CNT_W'(1);
      grp_atomic         <= em_n >= CNT_W'(2);

      solo_valid <= in_valid && !fuse_in;
      solo_kind  <= in_kind;
      solo_reg   <= in_reg;
    end
  end

  AST_SP_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid[MAX_RUN] |-> grp_sp_amt == AMT_W'(SLOT * $countones(grp_valid[MAX_RUN-1:0]))); // R3
  AST_ATOMIC_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    grp_atomic |-> grp_valid[MAX_RUN] && grp_valid[1]); // R8
  AST_FULL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> grp_valid[MAX_RUN-1] && acc_n == '0); // R4
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    acc_n < CNT_W'(MAX_RUN)); // R4
  AST_SP_REG_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_reg == REG_W'(SP_REG) |=> solo_valid); // R6
  AST_RAW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    grp_raw |-> grp_valid[0] && !grp_valid[1] && !grp_valid[MAX_RUN] && !grp_atomic); // R7
  AST_IDLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> acc_n == '0); // R5
endmodule

// File: tb/push_pop_fuser_bench.sv
module push_pop_fuser_bench;
  localparam int SP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_kind = '0;
  logic [4:0]  in_reg = '0;
  logic [4:0]  grp_valid;
  logic [19:0] grp_reg;
  logic [31:0] grp_off;
  logic [5:0]  grp_sp_amt;
  logic        grp_pop, grp_raw, grp_atomic, solo_valid;
  logic [1:0]  solo_kind;
  logic [4:0]  solo_reg;

  push_pop_fuser u_push_pop_fuser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind), .in_reg(in_reg),
    .grp_valid(grp_valid), .grp_reg(grp_reg), .grp_off(grp_off), .grp_sp_amt(grp_sp_amt),
    .grp_pop(grp_pop), .grp_raw(grp_raw), .grp_atomic(grp_atomic),
    .solo_valid(solo_valid), .solo_kind(solo_kind), .solo_reg(solo_reg));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;

  int q[$];
  bit qpop;
  int e_n, e_reg[4];
  bit e_pop, e_sv;
  int e_sk, e_sr;

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic emit();
    e_n = q.size();
    e_pop = qpop;
    for (int i = 0; i < q.size(); i++) e_reg[i] = q[i];
    q.delete();
  endtask

  task automatic model(bit v, int k, int r);
    bit fus, pp;
    e_n = 0; e_sv = 0;
    pp  = (k == 2);
    fus = v && (k == 1 || k == 2) && r != SP;
    if (fus && (q.size() == 0 || qpop == pp)) begin
      q.push_back(r); qpop = pp;
      if (q.size() == 4) emit();
    end else begin
      if (q.size() > 0) emit();
      if (fus) begin q.push_back(r); qpop = pp; end
      else if (v) begin e_sv = 1; e_sk = k; e_sr = r; end
    end
  endtask

  task automatic compare();
    string vt = (e_n == 4) ? "R4 group valid" : "R5 group valid";
    for (int i = 0; i < 4; i++) begin
      cmp(vt, int'(grp_valid[i]), int'(i < e_n));
      if (i < e_n && e_n >= 2) begin
        cmp(e_pop ? "R2 reg" : "R1 reg", int'(grp_reg[i*5 +: 5]), e_reg[i]);
        cmp(e_pop ? "R2 offset" : "R1 offset", int'($signed(grp_off[i*8 +: 8])),
            e_pop ? 8*i : -8*(i+1));
      end
    end
    cmp("R3 sp slot", int'(grp_valid[4]), int'(e_n >= 2));
    if (e_n >= 2) begin
      cmp("R3 sp amount", int'(grp_sp_amt), 8*e_n);
      cmp("R3 direction", int'(grp_pop), int'(e_pop));
    end
    cmp("R7 raw", int'(grp_raw), int'(e_n == 1));
    if (e_n == 1) begin
      cmp("R7 raw reg", int'(grp_reg[4:0]), e_reg[0]);
      cmp("R7 raw kind", int'(grp_pop), int'(e_pop));
    end
    cmp("R8 atomic", int'(grp_atomic), int'(e_n >= 2));
    cmp("R9 solo valid", int'(solo_valid), int'(e_sv));
    if (e_sv) begin
      cmp(e_sr == SP ? "R6 solo kind" : "R9 solo kind", int'(solo_kind), e_sk);
      cmp(e_sr == SP ? "R6 solo reg" : "R9 solo reg", int'(solo_reg), e_sr);
    end
  endtask

  task automatic drive(bit v, int k, int r);
    @(negedge clk);
    compare();
    model(v, k, r);
    in_valid = v; in_kind = 2'(k); in_reg = 5'(r);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R10 group valid", int'(grp_valid), 0);
    cmp("R10 atomic", int'(grp_atomic), 0);
    cmp("R10 raw", int'(grp_raw), 0);
    cmp("R10 solo", int'(solo_valid), 0);
    rst_n = 1'b1;
    e_n = 0; e_sv = 0;
    // R1 R3 R9: three pushes broken by an other op
    drive(1, 1, 1); drive(1, 1, 5); drive(1, 1, 3); drive(1, 0, 9);
    // R2: two pops broken by idle (R5)
    drive(1, 2, 7); drive(1, 2, 0); idle(2);
    // R7 R5: alternating singles
    drive(1, 1, 6); drive(1, 2, 6); drive(1, 1, 2); idle(1);
    // R4: five pushes then four pops
    for (int i = 0; i < 5; i++) drive(1, 1, 10 + i);
    for (int i = 0; i < 4; i++) drive(1, 2, 20 + i);
    idle(1);
    // R6: stack-pointer register breaks runs
    drive(1, 1, 1); drive(1, 1, 2); drive(1, 1, 3); drive(1, 1, SP);
    drive(1, 2, SP); drive(1, 2, 8); drive(1, 3, 11); idle(2);
    for (int n = 0; n < 3000; n++) begin
      int p = $urandom_range(0, 9);
      if (p < 2) drive(0, 0, 0);
      else drive(1, (p < 5) ? 1 : (p < 8) ? 2 : ((p == 8) ? 0 : 3), $urandom_range(0, 7));
    end
    idle(3);
    finish_run();
  end
endmodule